// File: doc/BRIEF.md
# Scatter-Gather Bus Window Translator

This block sits between a local host bus and a remote backplane bus and turns each local access that falls inside its window into one remote bus cycle. The window is cut into 4 KiB segments. A table holds one entry per segment, and each entry is programmed on its own. Neighbouring local segments can therefore point at remote pages that are far apart, and software sees one contiguous local region.

Each entry holds four things: a valid flag, the remote page number, the address-space class used for the remote cycle, and two swap options (byte swap and word swap). The swap options reorder the data in both directions. Entries are written through a dedicated map-write port. Accesses arrive on a request/acknowledge port that carries address, data, a write flag and a size code. Only one access is in flight at a time. The host request is held until the block acknowledges it. The block holds its remote request until the remote side acknowledges it.

Top module: `sgw_window_xlate`

## Requirements
- R1: After reset, `acc_ack`, `acc_err` and `rem_req` are low and every table entry is invalid, so any access before the first map write completes with an error and issues no remote cycle.
- R2: The entry index is `acc_addr[LA_W-1:12]`. The remote address is the entry's 20-bit page number followed by `acc_addr[11:0]`, so adjacent local segments may reach unrelated remote pages.
- R3: `rem_space` carries the entry's space code: 0 selects A16 cycles, 1 selects A24 and 2 selects A32. Code 3 is passed through unchanged.
- R4: `rem_size` equals `acc_size` (0 = 8 bit, 1 = 16 bit, 2 = 32 bit). Before any swap, the lane mask has bit k set for each byte k covered: one bit at `acc_addr[1:0]`, two bits starting at `acc_addr[1:0]`, or all four bits. Lane k is data bits [8k+7:8k].
- R5: With byte swap set, the bytes in lanes 0 and 1 trade places, and so do the bytes in lanes 2 and 3. This applies to write data, to read data returned to the host, and to the lane mask.
- R6: With word swap set, the 16-bit halves trade places (lanes 0,1 with lanes 2,3) in write data, read data and lane mask. With both options set, the byte order is fully reversed.
- R7: An access that hits an entry whose valid flag is clear is acknowledged with `acc_err` high and issues no remote cycle.
- R8: A misaligned access is acknowledged with `acc_err` high and issues no remote cycle. Misaligned means a 16-bit access with `acc_addr[0]` set, a 32-bit access with `acc_addr[1:0]` non-zero, or size code 3.
- R9: A map write changes only the addressed entry and applies to every access started after the write cycle.
- R10: `rem_req` stays high with stable fields until `rem_ack`. `acc_ack` is a one-cycle pulse exactly one cycle after the `rem_ack` cycle, and never overlaps `rem_req`. On reads, `acc_rdata` holds the swapped remote data.
- R11: The window spans NUM_ENTRIES segments (up to 8192, which is 32 MiB). The highest entry index translates like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Write one table entry |
| map_idx | input | IDX_W | Entry index to write |
| map_valid | input | 1 | Valid flag for the entry |
| map_space | input | 2 | Address-space code for the entry |
| map_bswap | input | 1 | Byte-swap option for the entry |
| map_wswap | input | 1 | Word-swap option for the entry |
| map_page | input | 20 | Remote page number for the entry |
| acc_req | input | 1 | Host access request, held until ack |
| acc_addr | input | LA_W | Local window address |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Host write data, lane-aligned |
| acc_ack | output | 1 | Access complete, one cycle |
| acc_err | output | 1 | Completion is an error (with ack) |
| acc_rdata | output | 32 | Read data, valid with ack |
| rem_req | output | 1 | Remote cycle request |
| rem_addr | output | 32 | Translated remote address |
| rem_space | output | 2 | Address-space code for the cycle |
| rem_size | output | 2 | Remote cycle size code |
| rem_we | output | 1 | Remote write flag |
| rem_lanes | output | 4 | Active byte lanes after swap |
| rem_wdata | output | 32 | Swapped write data |
| rem_ack | input | 1 | Remote cycle complete |
| rem_rdata | input | 32 | Remote read data, valid with rem_ack |

## Verification
A corrupted table entry appears in the next access that touches that segment: wrong page bits on `rem_addr`, a wrong `rem_space`, or data and lanes permuted the wrong way, all visible while `rem_req` is high. A lost valid flag or a broken alignment test shows in the first cycle after the request, as a remote request where an error acknowledge was due, or the other way round. A sequencing fault shows as an acknowledge that arrives early, late, or while the remote request is still pending. Each of these is observed within the access that triggers it.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int SEG_BITS    = 12;
  localparam int RADDR_W     = 32;
  localparam int PAGE_W      = RADDR_W - SEG_BITS;
  localparam int MAX_ENTRIES = 8192;

  localparam logic [1:0] SZ_8  = 2'd0;
  localparam logic [1:0] SZ_16 = 2'd1;
  localparam logic [1:0] SZ_32 = 2'd2;

  typedef struct packed {
    logic              valid;
    logic [1:0]        space;
    logic              bswap;
    logic              wswap;
    logic [PAGE_W-1:0] page;
  } map_entry_t;

  // alignment rule for one access
  function automatic logic is_aligned(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_8:    is_aligned = 1'b1;
      SZ_16:   is_aligned = ~off[0];
      SZ_32:   is_aligned = (off == 2'b00);
      default: is_aligned = 1'b0;
    endcase
  endfunction

  // byte lanes covered before any swap
  function automatic logic [3:0] size_lanes(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_8:    size_lanes = 4'b0001 << off;
      SZ_16:   size_lanes = off[1] ? 4'b1100 : 4'b0011;
      default: size_lanes = 4'b1111;
    endcase
  endfunction

  // lane mask follows the same permutation as the data
  function automatic logic [3:0] swap_lanes(input logic [3:0] l, input logic bs, input logic ws);
    case ({ws, bs})
      2'b01:   swap_lanes = {l[2], l[3], l[0], l[1]};
      2'b10:   swap_lanes = {l[1:0], l[3:2]};
      2'b11:   swap_lanes = {l[0], l[1], l[2], l[3]};
      default: swap_lanes = l;
    endcase
  endfunction
endpackage

// File: rtl/sgw_lane_swap.sv
module sgw_lane_swap (
  input  logic        bswap,
  input  logic        wswap,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  always_comb begin
    case ({wswap, bswap})
      2'b01:   dout = {din[23:16], din[31:24], din[7:0], din[15:8]};
      2'b10:   dout = {din[15:0], din[31:16]};
      2'b11:   dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/sgw_map_table.sv
module sgw_map_table
  import sgw_pkg::*;
#(
  parameter  int NUM_ENTRIES = 1024,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  map_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output map_entry_t       rd_entry
);
  map_entry_t tbl [NUM_ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_entry;
    end
  end

  assign rd_entry = tbl[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_idx)] == $past(wr_entry)); // R9
endmodule

// File: rtl/sgw_window_xlate.sv
module sgw_window_xlate
  import sgw_pkg::*;
#(
  parameter  int NUM_ENTRIES = 1024,
  localparam int IDX_W       = $clog2(NUM_ENTRIES),
  localparam int LA_W        = IDX_W + SEG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_we,
  input  logic [IDX_W-1:0]  map_idx,
  input  logic              map_valid,
  input  logic [1:0]        map_space,
  input  logic              map_bswap,
  input  logic              map_wswap,
  input  logic [PAGE_W-1:0] map_page,
  input  logic              acc_req,
  input  logic [LA_W-1:0]   acc_addr,
  input  logic              acc_we,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic              acc_ack,
  output logic              acc_err,
  output logic [31:0]       acc_rdata,
  output logic              rem_req,
  output logic [RADDR_W-1:0] rem_addr,
  output logic [1:0]        rem_space,
  output logic [1:0]        rem_size,
  output logic              rem_we,
  output logic [3:0]        rem_lanes,
  output logic [31:0]       rem_wdata,
  input  logic              rem_ack,
  input  logic [31:0]       rem_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} state_e;
  state_e state;

  map_entry_t wr_ent, lk_ent;
  assign wr_ent = '{valid: map_valid, space: map_space, bswap: map_bswap,
                    wswap: map_wswap, page: map_page};

  sgw_map_table #(.NUM_ENTRIES(NUM_ENTRIES)) table_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(map_we), .wr_idx(map_idx), .wr_entry(wr_ent),
    .rd_idx(acc_addr[LA_W-1:SEG_BITS]), .rd_entry(lk_ent)
  );

  // named events for the assertions
  logic start_evt, addr_ok, lookup_ok, remote_done;
  assign start_evt   = (state == ST_IDLE) && acc_req;
  assign addr_ok     = is_aligned(acc_size, acc_addr[1:0]);
  assign lookup_ok   = lk_ent.valid && addr_ok;
  assign remote_done = (state == ST_BUSY) && rem_ack;

  logic [31:0] wdata_sw, rdata_sw;
  logic        bs_q, ws_q;

  sgw_lane_swap wr_swap_i (.bswap(lk_ent.bswap), .wswap(lk_ent.wswap),
                           .din(acc_wdata), .dout(wdata_sw));
  sgw_lane_swap rd_swap_i (.bswap(bs_q), .wswap(ws_q),
                           .din(rem_rdata), .dout(rdata_sw));

  logic [PAGE_W-1:0]   page_q;
  logic [SEG_BITS-1:0] off_q;
  logic [1:0]          space_q, size_q;
  logic                we_q, err_q;
  logic [3:0]          lanes_q;
  logic [31:0]         wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err_q   <= 1'b0;
      page_q  <= '0;
      off_q   <= '0;
      space_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      bs_q    <= 1'b0;
      ws_q    <= 1'b0;
      lanes_q <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (acc_req) begin
          if (lookup_ok) begin
            page_q  <= lk_ent.page;
            off_q   <= acc_addr[SEG_BITS-1:0];
            space_q <= lk_ent.space;
            size_q  <= acc_size;
            we_q    <= acc_we;
            bs_q    <= lk_ent.bswap;
            ws_q    <= lk_ent.wswap;
            lanes_q <= swap_lanes(size_lanes(acc_size, acc_addr[1:0]),
                                  lk_ent.bswap, lk_ent.wswap);
            wdata_q <= wdata_sw;
            err_q   <= 1'b0;
            state   <= ST_BUSY;
          end else begin
            err_q <= 1'b1;
            state <= ST_RESP;
          end
        end
        ST_BUSY: if (rem_ack) begin
          if (!we_q) rdata_q <= rdata_sw;
          state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rem_req   = (state == ST_BUSY);
  assign rem_addr  = {page_q, off_q};
  assign rem_space = space_q;
  assign rem_size  = size_q;
  assign rem_we    = we_q;
  assign rem_lanes = lanes_q;
  assign rem_wdata = wdata_q;
  assign acc_ack   = (state == ST_RESP);
  assign acc_err   = (state == ST_RESP) && err_q;
  assign acc_rdata = rdata_q;

  AST_NO_REMOTE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !lk_ent.valid |=> !rem_req && acc_err); // R7
  AST_NO_REMOTE_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !addr_ok |=> !rem_req && acc_err); // R8
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> acc_ack); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req |-> !acc_ack); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req && !rem_ack |=> rem_req && $stable(rem_addr) && $stable(rem_lanes)); // R10
  AST_ACK_FOLLOWS_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    remote_done |=> acc_ack && !acc_err); // R10
  AST_LANES_MATCH_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req |-> $countones(rem_lanes) == ((rem_size == SZ_8) ? 1 : (rem_size == SZ_16) ? 2 : 4)); // R4
endmodule

// File: tb/sgw_window_xlate_tb.sv
module sgw_window_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_ENTRIES = 1024;
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int LA_W = IDX_W + 12;
  localparam logic [31:0] RD_MASK = 32'h5AC3_0F96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic map_we = 0, map_valid = 0, map_bswap = 0, map_wswap = 0;
  logic [IDX_W-1:0] map_idx = '0;
  logic [1:0] map_space = '0;
  logic [19:0] map_page = '0;
  logic acc_req = 0, acc_we = 0;
  logic [LA_W-1:0] acc_addr = '0;
  logic [1:0] acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic acc_ack, acc_err, rem_req, rem_we;
  logic [31:0] acc_rdata, rem_addr, rem_wdata;
  logic [1:0] rem_space, rem_size;
  logic [3:0] rem_lanes;
  logic rem_ack = 0;
  logic [31:0] rem_rdata = '0;

  sgw_window_xlate #(.NUM_ENTRIES(NUM_ENTRIES)) dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;

  // bench shadow of programmed entries
  logic [19:0] sh_page [NUM_ENTRIES];
  logic [1:0]  sh_space [NUM_ENTRIES];
  logic        sh_bs [NUM_ENTRIES];
  logic        sh_ws [NUM_ENTRIES];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model_swap(input logic [31:0] d, input logic bs, input logic ws);
    int m = {30'd0, ws, bs};
    for (int j = 0; j < 4; j++) model_swap[8*j +: 8] = d[8*(j ^ m) +: 8];
  endfunction

  function automatic logic [3:0] model_lanes(input logic [1:0] sz, input logic [1:0] off,
                                             input logic bs, input logic ws);
    logic [3:0] raw;
    int m = {30'd0, ws, bs};
    raw = (sz == 2'd0) ? (4'b0001 << off) : (sz == 2'd1) ? (4'b0011 << off) : 4'b1111;
    for (int j = 0; j < 4; j++) model_lanes[j] = raw[j ^ m];
  endfunction

  task automatic map_write(input int idx, input logic v, input logic [1:0] sp,
                           input logic bs, input logic ws, input logic [19:0] pg);
    @(negedge clk);
    map_we = 1; map_idx = idx[IDX_W-1:0]; map_valid = v; map_space = sp;
    map_bswap = bs; map_wswap = ws; map_page = pg;
    sh_page[idx] = pg; sh_space[idx] = sp; sh_bs[idx] = bs; sh_ws[idx] = ws;
    @(negedge clk);
    map_we = 0;
  endtask

  logic        r_err, r_rem, r_we, r_tim;
  logic [31:0] r_rd, r_addr, r_wd;
  logic [1:0]  r_sp, r_sz;
  logic [3:0]  r_ln;

  task automatic do_access(input logic [LA_W-1:0] addr, input logic [1:0] sz,
                           input logic we, input logic [31:0] wd, input int delay);
    logic done = 0;
    @(negedge clk);
    acc_addr = addr; acc_size = sz; acc_we = we; acc_wdata = wd; acc_req = 1;
    r_rem = 0; r_tim = 1; r_err = 0; r_rd = '0;
    for (int n = 0; n < 40 && !done; n++) begin
      @(negedge clk);
      if (acc_ack) begin
        r_err = acc_err; r_rd = acc_rdata; done = 1;
      end else if (rem_req) begin
        r_rem = 1; r_addr = rem_addr; r_sp = rem_space; r_sz = rem_size;
        r_ln = rem_lanes; r_we = rem_we; r_wd = rem_wdata;
        for (int d = 0; d < delay; d++) begin
          @(negedge clk);
          if (!rem_req || rem_addr !== r_addr || acc_ack) r_tim = 0;
        end
        rem_rdata = r_addr ^ RD_MASK; rem_ack = 1;
        @(negedge clk);
        rem_ack = 0;
        if (!acc_ack || rem_req) r_tim = 0;
        r_err = acc_err; r_rd = acc_rdata; done = 1;
      end
    end
    if (!done) r_tim = 0;
    acc_req = 0;
  endtask

  // full check of a valid access against the shadow table
  task automatic check_ok(input string tag, input logic [LA_W-1:0] addr, input logic [1:0] sz,
                          input logic we, input logic [31:0] wd, input int delay);
    int idx = int'(addr[LA_W-1:12]);
    logic [31:0] eaddr = {sh_page[idx], addr[11:0]};
    do_access(addr, sz, we, wd, delay);
    chk({tag, " R7 remote issued"}, {31'd0, r_rem}, 32'd1);
    chk({tag, " R2 addr"}, r_addr, eaddr);
    chk({tag, " R3 space"}, {30'd0, r_sp}, {30'd0, sh_space[idx]});
    chk({tag, " R4 size"}, {30'd0, r_sz}, {30'd0, sz});
    chk({tag, " R5 R6 lanes"}, {28'd0, r_ln}, {28'd0, model_lanes(sz, addr[1:0], sh_bs[idx], sh_ws[idx])});
    chk({tag, " R10 timing"}, {31'd0, r_tim}, 32'd1);
    chk({tag, " R7 no err"}, {31'd0, r_err}, 32'd0);
    if (we) chk({tag, " R5 R6 wdata"}, r_wd, model_swap(wd, sh_bs[idx], sh_ws[idx]));
    else    chk({tag, " R10 rdata"}, r_rd, model_swap(eaddr ^ RD_MASK, sh_bs[idx], sh_ws[idx]));
  endtask

  task automatic check_err(input string tag, input logic [LA_W-1:0] addr, input logic [1:0] sz);
    do_access(addr, sz, 1'b0, 32'h0, 0);
    chk({tag, " err"}, {31'd0, r_err}, 32'd1);
    chk({tag, " no remote"}, {31'd0, r_rem}, 32'd0);
  endtask

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [11:0] off;
    logic [1:0]  sz;
    logic        we;
    logic [31:0] wd;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{10'd0,    12'h000, 2'd2, 1'b1, 32'h1122_3344},
    '{10'd0,    12'hFFC, 2'd2, 1'b0, 32'h0},
    '{10'd1,    12'h010, 2'd2, 1'b1, 32'hAABB_CCDD},
    '{10'd1,    12'h003, 2'd0, 1'b1, 32'h4400_0000},
    '{10'd2,    12'h102, 2'd1, 1'b0, 32'h0},
    '{10'd2,    12'h020, 2'd2, 1'b1, 32'h0102_0304},
    '{10'd3,    12'h7F1, 2'd0, 1'b0, 32'h0},
    '{10'd3,    12'h006, 2'd1, 1'b1, 32'hBEEF_0000},
    '{10'd0,    12'h801, 2'd0, 1'b0, 32'h0},
    '{10'd1023, 12'hABE, 2'd1, 1'b1, 32'h9876_0000}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired got=%0d exp<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 acc_ack", {31'd0, acc_ack}, 32'd0);
    chk("R1 acc_err", {31'd0, acc_err}, 32'd0);
    chk("R1 rem_req", {31'd0, rem_req}, 32'd0);
    check_err("R1 unprogrammed entry", {10'd5, 12'h000}, 2'd2);

    // program scattered pages
    map_write(0,    1, 2'd2, 0, 0, 20'h12345);
    map_write(1,    1, 2'd1, 1, 0, 20'h00ABC);
    map_write(2,    1, 2'd0, 0, 1, 20'hFFFF0);
    map_write(3,    1, 2'd2, 1, 1, 20'h00001);
    map_write(1023, 1, 2'd1, 0, 0, 20'h7777A);

    foreach (VECS[i]) begin
      check_ok($sformatf("vec%0d", i), {VECS[i].idx, VECS[i].off}, VECS[i].sz,
               VECS[i].we, VECS[i].wd, i % 4);
    end

    // R11: highest entry, full word read
    check_ok("R11 last entry", {10'd1023, 12'hFF8}, 2'd2, 1'b0, 32'h0, 2);

    // R8: misaligned and reserved size
    check_err("R8 half odd", {10'd0, 12'h001}, 2'd1);
    check_err("R8 word off2", {10'd0, 12'h002}, 2'd2);
    check_err("R8 size3", {10'd0, 12'h000}, 2'd3);

    // R7: invalidate entry 2
    map_write(2, 0, 2'd0, 0, 1, 20'hFFFF0);
    check_err("R7 invalidated", {10'd2, 12'h040}, 2'd2);

    // R9: rewrite entry 0, neighbour untouched
    map_write(0, 1, 2'd0, 1, 0, 20'h0ABCD);
    check_ok("R9 rewritten", {10'd0, 12'h124}, 2'd2, 1'b1, 32'hCAFE_F00D, 1);
    check_ok("R9 neighbour", {10'd1, 12'h124}, 2'd2, 1'b0, 32'h0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule